// File: doc/BRIEF.md
# System MMU Control and Fault Register File

This block is the software-visible register file of a per-master address translation unit, together with the logic that records translation faults. Software reads and writes 32-bit registers through a simple strobe port. The block drives the translation engine's enable, stall, page-table base, level-1 table size and a one-cycle TLB invalidate pulse. It also drives a level interrupt line towards the interrupt controller.

The translation engine reports faults on a vector of eight event strobes, one per fault type, and gives a faulting address for each type. An accepted fault sets its status bit, records the address in the register shared by its category and stalls the engine straight away. The stall holds until software writes the control register again. Software clears status bits by writing ones to the clear register. An address register only captures a new address when no status bit of its category is pending.

Top module: `smmu_csr_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, and `xlat_en`, `xlat_stall`, `l1_small`, `tlb_flush` and `irq` are 0.
- R2: The control register at offset 0x000 stores three bits, read back in bits [2:0]. Bit 0 drives `xlat_en`, bit 1 drives `xlat_stall` and bit 2 enables the interrupt. Writing 0x5 means running, 0x7 means stalled and 0x0 means off.
- R3: The table base register at 0x014 stores all 32 bits and drives `tbl_base`. At 0x004, only bit 5 is stored; it drives `l1_small` (1 selects a 4 KB level-1 table, 0 selects a 16 KB one) and the other bits read 0.
- R4: A write to 0x00C with bit 0 set raises `tlb_flush` for exactly one cycle, in the cycle after the write. A write with bit 0 clear raises nothing. The offset reads 0.
- R5: The status register at 0x018 holds one bit per fault type: bit 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write access. An accepted event on `flt_vld[N]` sets bit N. Bits [31:8] read 0.
- R6: Each fault type writes its address into one shared register. Type 0 goes to 0x024. Types 2, 6 and 7 go to 0x028. Types 1, 4 and 5 go to 0x02C. Type 3 goes to 0x030.
- R7: When several accepted events of one category arrive in the same cycle, that category's register takes the address of the lowest-numbered type. All of their status bits are set.
- R8: An address register is not overwritten while any status bit of its category is set, as seen before the current cycle's update.
- R9: Writing to 0x01C clears exactly the status bits written as 1. A fault accepted in the same cycle sets its bit anyway. The offset reads 0.
- R10: An accepted fault sets control bit 1 (stall), and it wins over a control write in the same cycle. The stall stays set until a later control write.
- R11: While control bit 0 is 0, fault events change neither the status register, nor the address registers, nor the stall bit.
- R12: `irq` is 1 exactly when control bit 2 is set and at least one status bit is set.
- R13: Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW (12) | Byte offset of the register |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Registered read data |
| flt_vld | input | 8 | One strobe per fault type, in status-bit order |
| flt_addr | input | 8*DW | Faulting address per type; type N in bits [N*DW +: DW] |
| xlat_en | output | 1 | Translation enable |
| xlat_stall | output | 1 | Engine stall (block) |
| tbl_base | output | DW (32) | Page-table base address |
| l1_small | output | 1 | 1 selects a 4 KB level-1 table |
| tlb_flush | output | 1 | One-cycle TLB invalidate pulse |
| irq | output | 1 | Level interrupt |

## Verification
Every register update, including a fault capture or a clear, is visible one clock edge after the stimulus. `reg_rdata` reflects the register state from before that same edge. `tlb_flush`, `xlat_stall` and `irq` follow one edge after the write or fault that causes them, and `irq` is a combinational function of the registers. The bench drives inputs on the falling edge and updates its model for the rising edge that follows. It then compares outputs and any pending read on the next falling edge, so each result is checked in the exact cycle it is due, against a model that steps in lockstep.

// File: rtl/smmu_csr_pkg.sv
// Shared constants, types and helpers for the translation-unit register file.
// Assumes eight fault types; the category mapping is fixed behaviour.
package smmu_csr_pkg;

    localparam int unsigned NUM_FAULT = 8;
    localparam int unsigned NUM_GRP   = 4;

    // Register byte offsets
    localparam int unsigned OFS_CTRL  = 32'h000;
    localparam int unsigned OFS_CFG   = 32'h004;
    localparam int unsigned OFS_FLUSH = 32'h00C;
    localparam int unsigned OFS_BASE  = 32'h014;
    localparam int unsigned OFS_STAT  = 32'h018;
    localparam int unsigned OFS_CLR   = 32'h01C;
    localparam int unsigned OFS_APAGE = 32'h024;
    localparam int unsigned OFS_AWR   = 32'h028;
    localparam int unsigned OFS_ARD   = 32'h02C;
    localparam int unsigned OFS_ABUS  = 32'h030;

    // Bit position of the small-table select in the configuration word
    localparam int unsigned CFG_SMALL_BIT = 5;

    // Address-register categories
    localparam logic [1:0] GRP_PAGE = 2'd0;
    localparam logic [1:0] GRP_WR   = 2'd1;
    localparam logic [1:0] GRP_RD   = 2'd2;
    localparam logic [1:0] GRP_BUS  = 2'd3;

    typedef struct packed {
        logic irq_en;
        logic stall;
        logic en;
    } ctrl_t;

    // Category of a fault type
    function automatic logic [1:0] fault_group(input int unsigned t);
        case (t)
            0:       return GRP_PAGE;
            3:       return GRP_BUS;
            1, 4, 5: return GRP_RD;
            default: return GRP_WR;
        endcase
    endfunction

    // Mask of the status bits belonging to one category
    function automatic logic [NUM_FAULT-1:0] group_mask(input logic [1:0] g);
        logic [NUM_FAULT-1:0] m;
        m = '0;
        for (int unsigned t = 0; t < NUM_FAULT; t++) begin
            m[t] = (fault_group(t) == g);
        end
        return m;
    endfunction

endpackage

// File: rtl/smmu_csr_decode.sv
// Address decoder: turns a write strobe and a byte offset into one write
// enable per writable register. Assumes offsets are compared in full.
module smmu_csr_decode
    import smmu_csr_pkg::*;
#(
    parameter int unsigned REG_AW = 12
) (
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    output logic              wr_ctrl,
    output logic              wr_cfg,
    output logic              wr_base,
    output logic              wr_flush,
    output logic              wr_clr
);

    // Write-enable decode per register
    always_comb begin
        wr_ctrl  = reg_we && (reg_addr == REG_AW'(OFS_CTRL));
        wr_cfg   = reg_we && (reg_addr == REG_AW'(OFS_CFG));
        wr_base  = reg_we && (reg_addr == REG_AW'(OFS_BASE));
        wr_flush = reg_we && (reg_addr == REG_AW'(OFS_FLUSH));
        wr_clr   = reg_we && (reg_addr == REG_AW'(OFS_CLR));
    end

endmodule

// File: rtl/smmu_csr_ctrl.sv
// Control, configuration, table base and flush-pulse registers.
// Assumes fault_taken is high in a cycle where a fault was accepted; that
// forces the stall bit after any software write of the same cycle.
module smmu_csr_ctrl
    import smmu_csr_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_cfg,
    input  logic          wr_base,
    input  logic          wr_flush,
    input  logic [DW-1:0] wdata,
    input  logic          fault_taken,
    output ctrl_t         ctrl_q,
    output logic          small_q,
    output logic [DW-1:0] base_q,
    output logic          flush_q
);

    // Control bits: software write, then fault forces stall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(wdata[2:0]);
            end
            if (fault_taken) begin
                ctrl_q.stall <= 1'b1;
            end
        end
    end

    // Level-1 table size select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            small_q <= 1'b0;
        end else if (wr_cfg) begin
            small_q <= wdata[CFG_SMALL_BIT];
        end
    end

    // Page-table base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_base) begin
            base_q <= wdata;
        end
    end

    // One-cycle invalidate pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
        end else begin
            flush_q <= wr_flush && wdata[0];
        end
    end

endmodule

// File: rtl/smmu_fault_log.sv
// Fault status and per-category fault address capture.
// Assumes accept is the translation-enable bit; events outside it are dropped.
// A category register loads only when none of its status bits is pending.
module smmu_fault_log
    import smmu_csr_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic [NUM_FAULT-1:0]    flt_vld,
    input  logic [NUM_FAULT*DW-1:0] flt_addr,
    input  logic                    wr_clr,
    input  logic [NUM_FAULT-1:0]    clr_bits,
    output logic [NUM_FAULT-1:0]    status_q,
    output logic [NUM_GRP*DW-1:0]   gaddr_q,
    output logic                    fault_taken
);

    logic [NUM_FAULT-1:0] raise;
    logic [NUM_FAULT-1:0] clr_mask;

    // Accepted events and clear mask
    always_comb begin
        raise       = accept ? flt_vld : '0;
        clr_mask    = wr_clr ? clr_bits : '0;
        fault_taken = |raise;
    end

    // Status: clear first, then set by accepted events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | raise;
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [NUM_FAULT-1:0] GMASK = group_mask(2'(g));
        logic [DW-1:0] pick;
        logic          hit;
        logic          busy;

        // Lowest-numbered accepted event in this category
        always_comb begin
            pick = '0;
            hit  = 1'b0;
            for (int t = NUM_FAULT - 1; t >= 0; t--) begin
                if (raise[t] && GMASK[t]) begin
                    pick = flt_addr[t*DW +: DW];
                    hit  = 1'b1;
                end
            end
            busy = |(status_q & GMASK);
        end

        // Address capture, held while the category is pending
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gaddr_q[g*DW +: DW] <= '0;
            end else if (hit && !busy) begin
                gaddr_q[g*DW +: DW] <= pick;
            end
        end
    end

endmodule

// File: rtl/smmu_csr_top.sv
// Register file and fault capture of a per-master translation unit.
// Assumes a single software port with registered read data (one cycle).
module smmu_csr_top
    import smmu_csr_pkg::*;
#(
    parameter int unsigned REG_AW = 12,
    parameter int unsigned DW     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic                    reg_rd,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [DW-1:0]           reg_wdata,
    output logic [DW-1:0]           reg_rdata,
    input  logic [NUM_FAULT-1:0]    flt_vld,
    input  logic [NUM_FAULT*DW-1:0] flt_addr,
    output logic                    xlat_en,
    output logic                    xlat_stall,
    output logic [DW-1:0]           tbl_base,
    output logic                    l1_small,
    output logic                    tlb_flush,
    output logic                    irq
);

    logic wr_ctrl, wr_cfg, wr_base, wr_flush, wr_clr;
    ctrl_t                  ctrl_w;
    logic                   small_w;
    logic [NUM_FAULT-1:0]   status_w;
    logic [NUM_GRP*DW-1:0]  gaddr_w;
    logic                   fault_taken;
    logic [DW-1:0]          rd_val;
    logic [DW-1:0]          rdata_q;

    smmu_csr_decode #(.REG_AW(REG_AW)) u_dec (
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .wr_ctrl  (wr_ctrl),
        .wr_cfg   (wr_cfg),
        .wr_base  (wr_base),
        .wr_flush (wr_flush),
        .wr_clr   (wr_clr)
    );

    smmu_csr_ctrl #(.DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wr_cfg      (wr_cfg),
        .wr_base     (wr_base),
        .wr_flush    (wr_flush),
        .wdata       (reg_wdata),
        .fault_taken (fault_taken),
        .ctrl_q      (ctrl_w),
        .small_q     (small_w),
        .base_q      (tbl_base),
        .flush_q     (tlb_flush)
    );

    smmu_fault_log #(.DW(DW)) u_flt (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (ctrl_w.en),
        .flt_vld     (flt_vld),
        .flt_addr    (flt_addr),
        .wr_clr      (wr_clr),
        .clr_bits    (reg_wdata[NUM_FAULT-1:0]),
        .status_q    (status_w),
        .gaddr_q     (gaddr_w),
        .fault_taken (fault_taken)
    );

    // Engine-facing outputs and interrupt level
    always_comb begin
        xlat_en    = ctrl_w.en;
        xlat_stall = ctrl_w.stall;
        l1_small   = small_w;
        irq        = ctrl_w.irq_en && (|status_w);
    end

    // Read multiplexer by offset
    always_comb begin
        rd_val = '0;
        case (reg_addr)
            REG_AW'(OFS_CTRL):  rd_val = DW'(ctrl_w);
            REG_AW'(OFS_CFG):   rd_val = DW'(small_w) << CFG_SMALL_BIT;
            REG_AW'(OFS_BASE):  rd_val = tbl_base;
            REG_AW'(OFS_STAT):  rd_val = DW'(status_w);
            REG_AW'(OFS_APAGE): rd_val = gaddr_w[GRP_PAGE*DW +: DW];
            REG_AW'(OFS_AWR):   rd_val = gaddr_w[GRP_WR*DW +: DW];
            REG_AW'(OFS_ARD):   rd_val = gaddr_w[GRP_RD*DW +: DW];
            REG_AW'(OFS_ABUS):  rd_val = gaddr_w[GRP_BUS*DW +: DW];
            default:            rd_val = '0;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rd_val;
        end
    end

    assign reg_rdata = rdata_q;

endmodule

// File: rtl/smmu_csr_chk.sv
// Temporal checks on the register file, attached by bind to the top module.
module smmu_csr_chk
    import smmu_csr_pkg::*;
#(
    parameter int unsigned REG_AW = 12,
    parameter int unsigned DW     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [REG_AW-1:0]    reg_addr,
    input logic [DW-1:0]        reg_wdata,
    input logic [NUM_FAULT-1:0] flt_vld,
    input logic                 xlat_en,
    input logic                 xlat_stall,
    input logic                 tlb_flush,
    input logic                 irq,
    input logic [NUM_FAULT-1:0] status
);

    logic ctrl_wr;
    logic clr_wr;
    assign ctrl_wr = reg_we && (reg_addr == REG_AW'(OFS_CTRL));
    assign clr_wr  = reg_we && (reg_addr == REG_AW'(OFS_CLR));

    // R4
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |=> !tlb_flush);

    // R4
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == REG_AW'(OFS_FLUSH) && reg_wdata[0]) |=> !tlb_flush);

    // R10
    fault_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_en && (|flt_vld)) |=> xlat_stall);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_stall && !ctrl_wr) |=> xlat_stall);

    // R11
    off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_en && !clr_wr) |=> $stable(status));

    // R12
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|status));

    // R5
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_en && flt_vld[0]) |=> status[0]);

endmodule

bind smmu_csr_top smmu_csr_chk #(.REG_AW(REG_AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .flt_vld    (flt_vld),
    .xlat_en    (xlat_en),
    .xlat_stall (xlat_stall),
    .tlb_flush  (tlb_flush),
    .irq        (irq),
    .status     (status_w)
);

// File: tb/smmu_csr_top_tb_top.sv
// Self-checking bench: random traffic plus directed cases against a model.
module smmu_csr_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NF = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic            reg_rd = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic [NF-1:0]   flt_vld = '0;
    logic [NF*DW-1:0] flt_addr = '0;
    logic            xlat_en, xlat_stall, l1_small, tlb_flush, irq;
    logic [DW-1:0]   tbl_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    smmu_csr_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flt_vld(flt_vld), .flt_addr(flt_addr), .xlat_en(xlat_en),
        .xlat_stall(xlat_stall), .tbl_base(tbl_base), .l1_small(l1_small),
        .tlb_flush(tlb_flush), .irq(irq)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Reference state
    logic [2:0]    m_ctrl;
    logic          m_small;
    logic [DW-1:0] m_base;
    logic [NF-1:0] m_stat;
    logic [DW-1:0] m_ad [4];   // 0 page, 1 write, 2 read, 3 bus
    logic          m_flush;
    logic          rd_pend;
    logic [DW-1:0] rd_exp;
    string         rd_tag;
    logic [DW-1:0] last_rd;

    function automatic int cat_of(int t);
        if (t == 0) return 0;
        if (t == 3) return 3;
        if (t == 1 || t == 4 || t == 5) return 2;
        return 1;
    endfunction

    function automatic logic [DW-1:0] mread(logic [AW-1:0] a);
        case (a)
            12'h000: return {29'd0, m_ctrl};
            12'h004: return {26'd0, m_small, 5'd0};
            12'h014: return m_base;
            12'h018: return {24'd0, m_stat};
            12'h024: return m_ad[0];
            12'h028: return m_ad[1];
            12'h02C: return m_ad[2];
            12'h030: return m_ad[3];
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(logic [AW-1:0] a);
        case (a)
            12'h000: return "R2";
            12'h004, 12'h014: return "R3";
            12'h00C: return "R4";
            12'h018: return "R5";
            12'h01C: return "R9";
            12'h024, 12'h028, 12'h02C, 12'h030: return "R6";
            default: return "R13";
        endcase
    endfunction

    task automatic chk(logic [DW-1:0] act, logic [DW-1:0] exp, string tag, string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = '0; m_small = 0; m_base = '0; m_stat = '0; m_flush = 0;
        for (int g = 0; g < 4; g++) m_ad[g] = '0;
        rd_pend = 0; rd_exp = '0; last_rd = '0; rd_tag = "";
    endtask

    // Compare all outputs and any pending read (called at a falling edge)
    task automatic check_outputs();
        chk({31'd0, xlat_en}, {31'd0, m_ctrl[0]}, "R2", "xlat_en");
        chk({31'd0, xlat_stall}, {31'd0, m_ctrl[1]}, "R10", "xlat_stall");
        chk(tbl_base, m_base, "R3", "tbl_base");
        chk({31'd0, l1_small}, {31'd0, m_small}, "R3", "l1_small");
        chk({31'd0, tlb_flush}, {31'd0, m_flush}, "R4", "tlb_flush");
        chk({31'd0, irq}, {31'd0, m_ctrl[2] & (|m_stat)}, "R12", "irq");
        if (rd_pend) begin
            chk(reg_rdata, rd_exp, rd_tag, "read");
            last_rd = rd_exp;
        end else begin
            chk(reg_rdata, last_rd, "R13", "rdata hold");
        end
    endtask

    // One cycle of stimulus; model steps for the coming rising edge
    task automatic step(bit we, bit rd, logic [AW-1:0] a, logic [DW-1:0] wd,
                        logic [NF-1:0] fv, logic [NF*DW-1:0] fa, string tag);
        logic [NF-1:0] acc, clrm;
        logic [DW-1:0] cand [4];
        bit            hit [4];
        reg_we = we; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        flt_vld = fv; flt_addr = fa;
        rd_pend = rd;
        rd_exp  = mread(a);
        rd_tag  = (tag != "") ? tag : tag_of(a);
        acc  = m_ctrl[0] ? fv : '0;
        clrm = (we && a == 12'h01C) ? wd[NF-1:0] : '0;
        for (int g = 0; g < 4; g++) begin hit[g] = 0; cand[g] = '0; end
        for (int t = 0; t < NF; t++) begin
            if (acc[t] && !hit[cat_of(t)]) begin
                hit[cat_of(t)]  = 1;
                cand[cat_of(t)] = fa[t*DW +: DW];
            end
        end
        for (int t = 0; t < NF; t++) begin
            if (m_stat[t]) hit[cat_of(t)] = 0;
        end
        for (int g = 0; g < 4; g++) if (hit[g]) m_ad[g] = cand[g];
        m_stat  = (m_stat & ~clrm) | acc;
        m_flush = we && a == 12'h00C && wd[0];
        if (we && a == 12'h000) m_ctrl = wd[2:0];
        if (|acc) m_ctrl[1] = 1'b1;
        if (we && a == 12'h004) m_small = wd[5];
        if (we && a == 12'h014) m_base = wd;
        @(negedge clk);
        check_outputs();
        reg_we = 0; reg_rd = 0; flt_vld = '0;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        step(1, 0, a, d, '0, '0, "");
    endtask

    task automatic rdc(logic [AW-1:0] a, string tag);
        step(0, 1, a, '0, '0, '0, tag);
    endtask

    function automatic logic [NF*DW-1:0] addrs(logic [DW-1:0] seed);
        logic [NF*DW-1:0] v;
        for (int t = 0; t < NF; t++) v[t*DW +: DW] = seed + DW'(t * 32'h100);
        return v;
    endfunction

    function automatic logic [AW-1:0] pick_addr(int k);
        case (k % 12)
            0: return 12'h000; 1: return 12'h004; 2: return 12'h00C;
            3: return 12'h014; 4: return 12'h018; 5: return 12'h01C;
            6: return 12'h024; 7: return 12'h028; 8: return 12'h02C;
            9: return 12'h030; 10: return 12'h008;
            default: return 12'h3F0;
        endcase
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs();

        // R1: reset values of all mapped registers
        for (int k = 0; k < 10; k++) rdc(pick_addr(k), "R1");

        // R11: faults while disabled are dropped
        step(0, 0, 12'h0, '0, 8'hFF, addrs(32'hDEAD0000), "R11");
        rdc(12'h018, "R11");
        rdc(12'h02C, "R11");
        chk({31'd0, xlat_stall}, 32'd0, "R11", "stall after ignored fault");

        // R2 / R3 / R4 / R13 directed
        wr(12'h000, 32'h5);
        wr(12'h004, 32'hFFFF_FFFF);
        rdc(12'h004, "R3");
        wr(12'h014, 32'h8001_C000);
        rdc(12'h014, "R3");
        wr(12'h00C, 32'h1);
        wr(12'h00C, 32'h0);
        wr(12'h3F0, 32'hFFFF_FFFF);
        rdc(12'h3F0, "R13");
        rdc(12'h000, "R13");

        // R7: read multi-hit and read security together
        begin
            logic [NF*DW-1:0] fa;
            fa = addrs(32'hA000_0000);
            step(0, 0, 12'h0, '0, 8'b0011_0010, fa, "R7");
            rdc(12'h02C, "R7");
            chk(reg_rdata, 32'hA000_0100, "R7", "lowest type address");
            rdc(12'h018, "R5");
            chk(reg_rdata, 32'h32, "R5", "status bits");
            // R8: read access alone while category pending
            step(0, 0, 12'h0, '0, 8'b0010_0000, addrs(32'hB000_0000), "R8");
            rdc(12'h02C, "R8");
            chk(reg_rdata, 32'hA000_0100, "R8", "address held");
            // R9: clear bit 1 only, and fault with clear in same cycle
            wr(12'h01C, 32'h2);
            rdc(12'h018, "R9");
            step(1, 0, 12'h01C, 32'h1, 8'h01, addrs(32'hC000_0000), "R9");
            rdc(12'h018, "R9");
            rdc(12'h01C, "R9");
            // R10: fault and control write in same cycle
            step(1, 0, 12'h000, 32'h5, 8'h08, addrs(32'hD000_0000), "R10");
            rdc(12'h000, "R10");
            rdc(12'h030, "R6");
            wr(12'h01C, 32'hFF);
            wr(12'h000, 32'h5);
        end

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int op;
            op = $urandom % 10;
            if (op < 3) begin
                logic [NF-1:0] fv;
                fv = ($urandom % 3 == 0) ? NF'($urandom) : NF'(1 << ($urandom % NF));
                step(0, $urandom % 2 == 0, pick_addr($urandom), '0, fv,
                     addrs($urandom), "");
            end else if (op < 6) begin
                rdc(pick_addr($urandom), "");
            end else if (op == 6) begin
                wr(12'h01C, $urandom);
            end else if (op == 7) begin
                logic [DW-1:0] cv;
                case ($urandom % 6)
                    0: cv = 32'h0; 1: cv = 32'h7; 2: cv = 32'h4;
                    default: cv = 32'h5;
                endcase
                wr(12'h000, cv);
            end else begin
                wr(pick_addr($urandom), $urandom);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule